// File: doc/BRIEF.md
# Interrupt Group Signal Mapper

This block takes one pending interrupt and its group configuration bits. It works out which interrupt group the interrupt belongs to. From that group, and from the exception level and security state the processor is running in, it decides whether the interrupt goes to the processor on the IRQ line or on the FIQ line.

A sticky control bit selects between two schemes. One scheme has two security states and three groups. The other has a single security state and two groups. Software can set this bit, but only a reset clears it. Message-based interrupts are given a fixed group, and their configuration bits are not used.

The block sits between an upstream arbiter, which presents the winning interrupt with a pending-valid strobe, and the processor's two interrupt request inputs. The resolved group and both request lines come from registers, so they are valid one cycle after the strobe.

Top module: `intGroupMapper`

## Requirements
- R1: In dual-security mode, a wired interrupt resolves to a group from its two configuration bits. Group bit 1 gives Non-secure Group 1 (`resolvedGroup` = 2'b10), whatever the modifier. Group bit 0 with modifier 0 gives Group 0 (2'b00). Group bit 0 with modifier 1 gives Secure Group 1 (2'b01).
- R2: In single-security mode, group bit 0 gives Group 0 (2'b00) and group bit 1 gives Group 1 (2'b11), and the modifier bit has no effect.
- R3: A write with `cfgWrEn`=1 and `cfgWrData`=1 sets the single-security bit, and `singleSecMode` shows it from the next cycle. A write of 0 leaves the bit unchanged. Only `rstN` low clears it.
- R4: A Group 0 interrupt is always requested on FIQ, never on IRQ.
- R5: While `curEl` is 3, every Group 1 interrupt (2'b01, 2'b10 or 2'b11) is requested on FIQ.
- R6: Below EL3 in dual-security mode, a Secure Group 1 interrupt while `curSecure`=0 goes to FIQ. A Non-secure Group 1 interrupt while `curSecure`=1 also goes to FIQ.
- R7: Below EL3, a Group 1 interrupt that matches the current security state goes to IRQ. In single-security mode every Group 1 interrupt counts as matching.
- R8: A message-based interrupt (`msgClass`=1) resolves to Non-secure Group 1 in dual-security mode and to Group 1 in single-security mode, and its group and modifier bits have no effect.
- R9: `irqReq` and `fiqReq` assert the cycle after `pendValid` is high and deassert the cycle after it drops. The two are never high together. `resolvedGroup` keeps its last value while `pendValid` is low.
- R10: After reset, `resolvedGroup` is 2'b00, both request lines are low and `singleSecMode` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Write strobe for the single-security control bit |
| cfgWrData | input | 1 | Write value; only 1 has an effect |
| pendValid | input | 1 | A pending interrupt is presented this cycle |
| grpBit | input | 1 | Interrupt group configuration bit |
| grpModBit | input | 1 | Group modifier configuration bit |
| msgClass | input | 1 | 1 = message-based interrupt, 0 = wired interrupt |
| curEl | input | ElW | Current exception level of the processor |
| curSecure | input | 1 | 1 = processor currently in secure state |
| resolvedGroup | output | 2 | Registered resolved group code |
| irqReq | output | 1 | Registered IRQ request |
| fiqReq | output | 1 | Registered FIQ request |
| singleSecMode | output | 1 | Current value of the sticky single-security bit |

## Verification
The hardest situation to reach is single-security mode followed by an attempt to leave it. The control bit can only be set, so every dual-mode vector has to run before the bit is written. After that the single-mode vectors run. The bench then writes a 0 to confirm the bit holds, and asserts reset to confirm that reset alone returns the block to three-group decoding. The bench also lines up EL3 against mismatched security states, and message-based interrupts with misleading group bits, so that each override is seen winning over the rule it competes with.

// File: rtl/intGroupMapper_pkg.sv
package intGroupMapper_pkg;

  typedef enum logic [1:0] {
    GRP_ZERO  = 2'b00,
    GRP_SEC1  = 2'b01,
    GRP_NSEC1 = 2'b10,
    GRP_ONE   = 2'b11
  } grpCode_t;

  typedef struct packed {
    logic capture;
    logic singleSec;
  } ctrlStrobe_t;

endpackage

// File: rtl/intGroupMapper_ctrl.sv
module intGroupMapper_ctrl
  import intGroupMapper_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic        cfgWrData,
  input  logic        pendValid,
  output ctrlStrobe_t strb
);

  logic stickyQ;

  // one-way bit: writes may only set it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stickyQ <= 1'b0;
    end else if (cfgWrEn && cfgWrData) begin
      stickyQ <= 1'b1;
    end
  end

  always_comb begin
    strb.capture   = pendValid;
    strb.singleSec = stickyQ;
  end

endmodule

// File: rtl/intGroupMapper_dp.sv
module intGroupMapper_dp
  import intGroupMapper_pkg::*;
#(
  parameter int ElW = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  ctrlStrobe_t    strb,
  input  logic           grpBit,
  input  logic           grpModBit,
  input  logic           msgClass,
  input  logic [ElW-1:0] curEl,
  input  logic           curSecure,
  output grpCode_t       grpQ,
  output logic           irqQ,
  output logic           fiqQ
);

  localparam logic [ElW-1:0] ElTop = ElW'((1 << ElW) - 1);

  grpCode_t grpNext;
  logic     wantFiq;

  always_comb begin
    if (strb.singleSec) begin
      grpNext = (msgClass || grpBit) ? GRP_ONE : GRP_ZERO;
    end else if (msgClass || grpBit) begin
      grpNext = GRP_NSEC1;
    end else if (grpModBit) begin
      grpNext = GRP_SEC1;
    end else begin
      grpNext = GRP_ZERO;
    end
  end

  always_comb begin
    if (grpNext == GRP_ZERO || curEl == ElTop) begin
      wantFiq = 1'b1;
    end else begin
      unique case (grpNext)
        GRP_SEC1:  wantFiq = !curSecure;
        GRP_NSEC1: wantFiq = curSecure;
        default:   wantFiq = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grpQ <= GRP_ZERO;
      irqQ <= 1'b0;
      fiqQ <= 1'b0;
    end else begin
      irqQ <= strb.capture && !wantFiq;
      fiqQ <= strb.capture && wantFiq;
      if (strb.capture) begin
        grpQ <= grpNext;
      end
    end
  end

endmodule

// File: rtl/intGroupMapper.sv
module intGroupMapper
  import intGroupMapper_pkg::*;
#(
  parameter int ElW = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           cfgWrEn,
  input  logic           cfgWrData,
  input  logic           pendValid,
  input  logic           grpBit,
  input  logic           grpModBit,
  input  logic           msgClass,
  input  logic [ElW-1:0] curEl,
  input  logic           curSecure,
  output logic [1:0]     resolvedGroup,
  output logic           irqReq,
  output logic           fiqReq,
  output logic           singleSecMode
);

  ctrlStrobe_t strb;
  grpCode_t    grpQ;

  intGroupMapper_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .pendValid (pendValid),
    .strb      (strb)
  );

  intGroupMapper_dp #(.ElW(ElW)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .grpBit    (grpBit),
    .grpModBit (grpModBit),
    .msgClass  (msgClass),
    .curEl     (curEl),
    .curSecure (curSecure),
    .grpQ      (grpQ),
    .irqQ      (irqReq),
    .fiqQ      (fiqReq)
  );

  assign resolvedGroup = grpQ;
  assign singleSecMode = strb.singleSec;

endmodule

// File: rtl/intGroupMapper_chk.sv
module intGroupMapper_chk #(
  parameter int ElW = 2
) (
  input logic           clk,
  input logic           rstN,
  input logic           cfgWrEn,
  input logic           cfgWrData,
  input logic           pendValid,
  input logic           grpBit,
  input logic           grpModBit,
  input logic           msgClass,
  input logic [ElW-1:0] curEl,
  input logic           curSecure,
  input logic [1:0]     resolvedGroup,
  input logic           irqReq,
  input logic           fiqReq,
  input logic           singleSecMode
);

  localparam logic [ElW-1:0] ElTop = ElW'((1 << ElW) - 1);

  AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    !(irqReq && fiqReq)); // R9

  AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !pendValid |=> (!irqReq && !fiqReq)); // R9

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    singleSecMode |=> singleSecMode); // R3

  AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgWrData) |=> singleSecMode); // R3

  AST_GROUP0_FIQ: assert property (@(posedge clk) disable iff (!rstN)
    (pendValid && !msgClass && !grpBit && (singleSecMode || !grpModBit))
      |=> (fiqReq && !irqReq && resolvedGroup == 2'b00)); // R4

  AST_TOP_EL_FIQ: assert property (@(posedge clk) disable iff (!rstN)
    (pendValid && curEl == ElTop) |=> (fiqReq && !irqReq)); // R5

  AST_MSG_NSEC: assert property (@(posedge clk) disable iff (!rstN)
    (pendValid && msgClass && !singleSecMode) |=> resolvedGroup == 2'b10); // R8

  AST_SINGLE_TWO_GROUPS: assert property (@(posedge clk) disable iff (!rstN)
    (pendValid && singleSecMode) |=> (resolvedGroup == 2'b00 || resolvedGroup == 2'b11)); // R2

  AST_GROUP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !pendValid |=> $stable(resolvedGroup)); // R9

endmodule

bind intGroupMapper intGroupMapper_chk #(.ElW(ElW)) chk_i (
  .clk           (clk),
  .rstN          (rstN),
  .cfgWrEn       (cfgWrEn),
  .cfgWrData     (cfgWrData),
  .pendValid     (pendValid),
  .grpBit        (grpBit),
  .grpModBit     (grpModBit),
  .msgClass      (msgClass),
  .curEl         (curEl),
  .curSecure     (curSecure),
  .resolvedGroup (resolvedGroup),
  .irqReq        (irqReq),
  .fiqReq        (fiqReq),
  .singleSecMode (singleSecMode)
);

// File: tb/intGroupMapper_tb_top.sv
module intGroupMapper_tb_top;

  localparam int ElW = 2;
  localparam int NumDual = 12;
  localparam int NumSingle = 6;

  // {grp, mod, msg, el[1:0], sec, expGrp[1:0], expIrq, expFiq}
  localparam logic [9:0] DualVec [NumDual] = '{
    10'b0_0_0_01_0_00_0_1,
    10'b0_0_0_11_1_00_0_1,
    10'b1_0_0_01_0_10_1_0,
    10'b1_1_0_10_0_10_1_0,
    10'b1_0_0_01_1_10_0_1,
    10'b0_1_0_01_1_01_1_0,
    10'b0_1_0_00_0_01_0_1,
    10'b0_1_0_11_1_01_0_1,
    10'b1_0_0_11_0_10_0_1,
    10'b0_0_1_01_0_10_1_0,
    10'b0_1_1_01_1_10_0_1,
    10'b1_0_0_00_0_10_1_0
  };

  localparam logic [9:0] SingleVec [NumSingle] = '{
    10'b0_1_0_01_1_00_0_1,
    10'b1_1_0_01_0_11_1_0,
    10'b1_0_0_01_1_11_1_0,
    10'b1_0_0_11_0_11_0_1,
    10'b0_1_1_10_0_11_1_0,
    10'b0_0_0_00_0_00_0_1
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic cfgWrData = 1'b0;
  logic pendValid = 1'b0;
  logic grpBit = 1'b0;
  logic grpModBit = 1'b0;
  logic msgClass = 1'b0;
  logic [ElW-1:0] curEl = '0;
  logic curSecure = 1'b0;
  logic [1:0] resolvedGroup;
  logic irqReq;
  logic fiqReq;
  logic singleSecMode;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  intGroupMapper #(.ElW(ElW)) dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .pendValid(pendValid), .grpBit(grpBit), .grpModBit(grpModBit),
    .msgClass(msgClass), .curEl(curEl), .curSecure(curSecure),
    .resolvedGroup(resolvedGroup), .irqReq(irqReq), .fiqReq(fiqReq),
    .singleSecMode(singleSecMode)
  );

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {grp,irq,fiq/mode} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic runVec(input string tag, input logic [9:0] v);
    @(negedge clk);
    pendValid = 1'b1;
    grpBit = v[9];
    grpModBit = v[8];
    msgClass = v[7];
    curEl = v[6:5];
    curSecure = v[4];
    @(negedge clk);
    check(tag, {resolvedGroup, irqReq, fiqReq}, v[3:0]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 during reset", {resolvedGroup, irqReq, fiqReq}, 4'b0000);
    check("R10 mode bit", {3'b000, singleSecMode}, 4'b0000);
    rstN = 1'b1;

    for (int i = 0; i < NumDual; i++) begin
      runVec("R1 R4 R5 R6 R7 R8 dual table", DualVec[i]);
    end

    // R9: drop of pending clears both lines, group holds (last was NS1)
    @(negedge clk);
    pendValid = 1'b0;
    grpBit = 1'b0;
    @(negedge clk);
    check("R9 drop", {resolvedGroup, irqReq, fiqReq}, 4'b1000);

    // R3: writing 0 has no effect
    cfgWrEn = 1'b1;
    cfgWrData = 1'b0;
    @(negedge clk);
    cfgWrEn = 1'b0;
    @(negedge clk);
    check("R3 write zero keeps dual mode", {3'b000, singleSecMode}, 4'b0000);

    // R3: set the sticky bit
    cfgWrEn = 1'b1;
    cfgWrData = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0;
    check("R3 set single mode", {3'b000, singleSecMode}, 4'b0001);

    for (int i = 0; i < NumSingle; i++) begin
      runVec("R2 R4 R5 R7 R8 single table", SingleVec[i]);
    end

    // R3: writing 0 cannot clear
    @(negedge clk);
    pendValid = 1'b0;
    cfgWrEn = 1'b1;
    cfgWrData = 1'b0;
    @(negedge clk);
    cfgWrEn = 1'b0;
    @(negedge clk);
    check("R3 sticky after write zero", {3'b000, singleSecMode}, 4'b0001);

    // R3/R10: reset clears sticky bit and outputs
    rstN = 1'b0;
    @(negedge clk);
    check("R3 reset clears mode", {3'b000, singleSecMode}, 4'b0000);
    check("R10 reset outputs", {resolvedGroup, irqReq, fiqReq}, 4'b0000);
    rstN = 1'b1;

    // R1: back in dual mode, secure group 1 decoding returns
    runVec("R1 dual after reset", 10'b0_1_0_01_1_01_1_0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule